// File: doc/BRIEF.md
# Serial EEPROM Write-Cycle Slave

This block is the device side of a three-wire serial EEPROM that accepts one instruction, WRITE. A host raises chip select, clocks in a frame on the serial data line (start bit, opcode, address, data word) and drops chip select. The block then runs a self-timed programming cycle of a fixed number of system-clock cycles, after which the addressed location in a 4 Kbit array holds the new word. The serial inputs are sampled on a free-running system clock, so the programming time does not depend on the serial clock.

The data width follows an organisation input or a build-time choice that forces byte or word mode. A second build-time choice selects when programming begins: either on the falling edge of chip select after a complete frame, or on the serial clock edge that samples the last data bit. While programming runs, the host can poll for completion. It drops chip select for at least a minimum low time and raises it again, and the serial output then shows busy (0) or ready (1).

The serial output is a drive value plus a drive enable, where enable low means high impedance. A read-only inspection port exposes the array byte by byte, so that stored contents can be observed without a read instruction.

Top module: `mw_eeprom_wr`

## Requirements
- R1: A frame opens with the first 1 sampled on a rising serial clock while chip select is high; earlier rising edges carrying 0 are skipped. The frame then carries opcode bits 0 then 1, the address MSB first, and the data MSB first.
- R2: In byte mode (forced, or organisation input low) the frame carries a 9-bit byte address and 8 data bits. In word mode (forced, or organisation input high) it carries an 8-bit word address w and 16 data bits, stored low byte at byte 2w and high byte at byte 2w+1. The mode is taken at the start bit.
- R3: In the chip-select-edge variant, programming starts on the falling edge of chip select only after the full frame has been clocked in. Holding chip select high does not start it, and a frame cut short by chip select falling writes nothing.
- R4: In the clock-edge variant, programming starts right after the rising serial clock that samples the last data bit, with chip select still high.
- R5: Programming lasts TWC system-clock cycles. The array location changes only at the end of the cycle.
- R6: When chip select rises after at least TCSL low cycles, and a programming cycle has been started and not cleared, the output is driven: 0 while programming, 1 once done. After a shorter low time it stays undriven.
- R7: A start bit followed by chip select falling clears the status, and later polls leave the output undriven.
- R8: The output is undriven while chip select is low and while a frame is being shifted in without a valid poll.
- R9: Frames that begin during programming, and frames whose opcode is not 0,1, change no array location.
- R10: After reset the output is undriven and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation select (1 = 16-bit words) when not forced |
| sdo_o | output | 1 | Serial data out value (ready = 1, busy = 0) |
| sdo_en_o | output | 1 | Drive enable for sdo_o; 0 means high impedance |
| peek_addr_i | input | 9 | Byte address of the inspection port |
| peek_data_o | output | 8 | Array byte at peek_addr_i |

## Verification
The bench builds two copies with TWC = 40 and TCSL = 6. Both values are short, so busy, ready and the minimum-low-time refusal each fall within a few dozen cycles of a frame. The first copy uses the chip-select-edge start and follows the organisation input, so both widths, the abort case, leading zeros, a wrong opcode and a frame during programming are reached on one instance. The second copy uses the clock-edge start with word mode forced, which shows the array updating while chip select is still high.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        ORG_PIN  = 2'd0,
        ORG_BYTE = 2'd1,
        ORG_WORD = 2'd2
    } org_sel_e;

    localparam int MEM_BITS = 4096;
    localparam int BYTE_DW  = 8;
    localparam int WORD_DW  = 16;
    localparam int NBYTES   = MEM_BITS / BYTE_DW;
    localparam int BYTE_AW  = $clog2(MEM_BITS / BYTE_DW);
    localparam int WORD_AW  = $clog2(MEM_BITS / WORD_DW);
    localparam int OPC_W    = 2;
    localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;
    localparam int SREG_W   = WORD_AW + WORD_DW;
    localparam int CNT_W    = $clog2(OPC_W + SREG_W + 1);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_FULL,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic               word;
        logic [BYTE_AW-1:0] addr;
        logic [WORD_DW-1:0] data;
    } wr_req_t;

    function automatic logic [CNT_W-1:0] frame_len(input logic word);
        if (word)
            return CNT_W'(OPC_W + WORD_AW + WORD_DW);
        return CNT_W'(OPC_W + BYTE_AW + BYTE_DW);
    endfunction

endpackage

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
    import mw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_i,
    input  logic    sclk_rise_i,
    input  logic    sdi_i,
    input  logic    word_i,
    input  logic    busy_i,
    output logic    start_o,
    output logic    done_o,
    output logic    full_o,
    output wr_req_t req_o
);

    rx_state_e         state;
    logic [SREG_W-1:0] sreg;
    logic [CNT_W-1:0]  cnt;
    logic              word_q;
    logic [CNT_W-1:0]  cnt_nx;

    assign cnt_nx  = cnt + 1'b1;
    assign start_o = cs_i && sclk_rise_i && sdi_i && (state == RX_IDLE);
    assign full_o  = (state == RX_FULL);

    always_ff @(posedge clk) begin
        if (rst || !cs_i) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            done_o <= 1'b0;
            if (rst) begin
                sreg   <= '0;
                word_q <= 1'b0;
            end
        end else begin
            done_o <= 1'b0;
            case (state)
                RX_IDLE: if (sclk_rise_i && sdi_i) begin
                    word_q <= word_i;
                    cnt    <= '0;
                    state  <= busy_i ? RX_SKIP : RX_SHIFT;
                end
                RX_SHIFT: if (sclk_rise_i) begin
                    sreg <= {sreg[SREG_W-2:0], sdi_i};
                    cnt  <= cnt_nx;
                    if (cnt == CNT_W'(1) && {sreg[0], sdi_i} != OPC_WRITE) begin
                        state <= RX_SKIP;
                    end else if (cnt_nx == frame_len(word_q)) begin
                        state  <= RX_FULL;
                        done_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_o.word = word_q;
        if (word_q) begin
            req_o.addr = {1'b0, sreg[WORD_DW +: WORD_AW]};
            req_o.data = sreg[WORD_DW-1:0];
        end else begin
            req_o.addr = sreg[BYTE_DW +: BYTE_AW];
            req_o.data = {{(WORD_DW-BYTE_DW){1'b0}}, sreg[BYTE_DW-1:0]};
        end
    end

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int TWC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    output logic busy_o,
    output logic commit_o
);

    localparam int CW = $clog2(TWC + 1);

    logic [CW-1:0] cnt;

    assign commit_o = busy_o && (cnt == CW'(TWC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (go_i && !busy_o) begin
            busy_o <= 1'b1;
            cnt    <= '0;
        end else if (busy_o) begin
            if (commit_o)
                busy_o <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mw_status.sv
module mw_status #(
    parameter int TCSL = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic cs_rise_i,
    input  logic cs_fall_i,
    input  logic start_i,
    input  logic go_i,
    input  logic busy_i,
    output logic sdo_o,
    output logic sdo_en_o
);

    localparam int LW = $clog2(TCSL + 1);

    logic [LW-1:0] low_cnt;
    logic          flag;
    logic          clr_pend;
    logic          poll;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            flag     <= 1'b0;
            clr_pend <= 1'b0;
            poll     <= 1'b0;
        end else begin
            if (cs_i)
                low_cnt <= '0;
            else if (low_cnt != LW'(TCSL))
                low_cnt <= low_cnt + 1'b1;

            if (go_i) begin
                flag     <= 1'b1;
                clr_pend <= 1'b0;
            end else if (cs_fall_i) begin
                if (clr_pend)
                    flag <= 1'b0;
                clr_pend <= 1'b0;
            end else if (start_i) begin
                clr_pend <= 1'b1;
            end

            if (!cs_i)
                poll <= 1'b0;
            else if (cs_rise_i && (low_cnt >= LW'(TCSL)) && flag)
                poll <= 1'b1;
        end
    end

    assign sdo_en_o = poll && cs_i;
    assign sdo_o    = sdo_en_o ? !busy_i : 1'b0;

endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  wr_req_t            req_i,
    input  logic [BYTE_AW-1:0] peek_addr_i,
    output logic [BYTE_DW-1:0] peek_data_o
);

    logic [BYTE_DW-1:0] mem [NBYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NBYTES; k++)
                mem[k] <= '1;
        end else if (we_i) begin
            if (req_i.word) begin
                mem[{req_i.addr[WORD_AW-1:0], 1'b0}] <= req_i.data[BYTE_DW-1:0];
                mem[{req_i.addr[WORD_AW-1:0], 1'b1}] <= req_i.data[WORD_DW-1:BYTE_DW];
            end else begin
                mem[req_i.addr] <= req_i.data[BYTE_DW-1:0];
            end
        end
    end

    assign peek_data_o = mem[peek_addr_i];

endmodule

// File: rtl/mw_eeprom_wr.sv
module mw_eeprom_wr
    import mw_pkg::*;
#(
    parameter org_sel_e ORG_SEL      = ORG_PIN,
    parameter bit       START_ON_CLK = 1'b0,
    parameter int       TWC          = 200,
    parameter int       TCSL         = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_i,
    input  logic               sclk_i,
    input  logic               sdi_i,
    input  logic               org_i,
    output logic               sdo_o,
    output logic               sdo_en_o,
    input  logic [BYTE_AW-1:0] peek_addr_i,
    output logic [BYTE_DW-1:0] peek_data_o
);

    logic    cs_q, sclk_q;
    logic    cs_rise, cs_fall, sclk_rise;
    logic    word_mode;
    logic    rx_start, rx_done, rx_full;
    wr_req_t rx_req, req_q;
    logic    busy, commit, prog_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_i;
            sclk_q <= sclk_i;
        end
    end

    assign cs_rise   = cs_i && !cs_q;
    assign cs_fall   = !cs_i && cs_q;
    assign sclk_rise = sclk_i && !sclk_q;
    assign word_mode = (ORG_SEL == ORG_WORD) || ((ORG_SEL == ORG_PIN) && org_i);

    mw_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_i       (cs_i),
        .sclk_rise_i(sclk_rise),
        .sdi_i      (sdi_i),
        .word_i     (word_mode),
        .busy_i     (busy),
        .start_o    (rx_start),
        .done_o     (rx_done),
        .full_o     (rx_full),
        .req_o      (rx_req)
    );

    generate
        if (START_ON_CLK) begin : g_clk_start
            assign prog_go = rx_done && !busy;
        end else begin : g_cs_start
            assign prog_go = cs_fall && rx_full && !busy;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (prog_go)
            req_q <= rx_req;
    end

    mw_prog_timer #(.TWC(TWC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go_i    (prog_go),
        .busy_o  (busy),
        .commit_o(commit)
    );

    mw_status #(.TCSL(TCSL)) u_status (
        .clk      (clk),
        .rst      (rst),
        .cs_i     (cs_i),
        .cs_rise_i(cs_rise),
        .cs_fall_i(cs_fall),
        .start_i  (rx_start),
        .go_i     (prog_go),
        .busy_i   (busy),
        .sdo_o    (sdo_o),
        .sdo_en_o (sdo_en_o)
    );

    mw_array u_array (
        .clk        (clk),
        .rst        (rst),
        .we_i       (commit),
        .req_i      (req_q),
        .peek_addr_i(peek_addr_i),
        .peek_data_o(peek_data_o)
    );

endmodule

// File: rtl/mw_eeprom_wr_chk.sv
module mw_eeprom_wr_chk #(
    parameter int TWC          = 200,
    parameter int TCSL         = 50,
    parameter bit START_ON_CLK = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic cs_i,
    input logic sdo_en_o,
    input logic busy,
    input logic go,
    input logic commit
);

    logic [31:0] busy_len;
    logic [15:0] low_run;
    logic [15:0] last_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
            low_run  <= '0;
            last_low <= '0;
        end else begin
            busy_len <= busy ? busy_len + 1 : '0;
            if (!cs_i) begin
                if (low_run != 16'hFFFF)
                    low_run <= low_run + 1'b1;
            end else begin
                if (low_run != 0)
                    last_low <= low_run;
                low_run <= '0;
            end
        end
    end

    a_r8_hiz_cs_low: assert property (@(posedge clk) disable iff (rst)
        !cs_i |-> !sdo_en_o);

    a_r9_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !go);

    a_r5_cycle_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == TWC));

    a_r5_commit_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(commit));

    a_r6_poll_low_time: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en_o) |-> (32'(last_low) >= TCSL));

    a_r3_cs_edge_start: assert property (@(posedge clk) disable iff (rst)
        (!START_ON_CLK && $rose(busy)) |-> (!$past(cs_i) && $past(cs_i, 2)));

    a_r4_clk_edge_start: assert property (@(posedge clk) disable iff (rst)
        (START_ON_CLK && $rose(busy)) |-> $past(cs_i, 2));

endmodule

bind mw_eeprom_wr mw_eeprom_wr_chk #(
    .TWC         (TWC),
    .TCSL        (TCSL),
    .START_ON_CLK(START_ON_CLK)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_i    (cs_i),
    .sdo_en_o(sdo_en_o),
    .busy    (busy),
    .go      (prog_go),
    .commit  (commit)
);

// File: tb/sim_mw_eeprom_wr.sv
`timescale 1ns/1ps
module sim_mw_eeprom_wr;
    import mw_pkg::*;

    localparam int TWC  = 40;
    localparam int TCSL = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cs = '0, sclk = '0, di = '0, org = '0;
    logic [1:0] sdo, sdo_en;
    logic [8:0] paddr [2];
    logic [7:0] pdata [2];
    logic [7:0] shadow [512];
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    mw_eeprom_wr #(.ORG_SEL(ORG_PIN), .START_ON_CLK(1'b0), .TWC(TWC), .TCSL(TCSL)) u0 (
        .clk(clk), .rst(rst), .cs_i(cs[0]), .sclk_i(sclk[0]), .sdi_i(di[0]), .org_i(org[0]),
        .sdo_o(sdo[0]), .sdo_en_o(sdo_en[0]), .peek_addr_i(paddr[0]), .peek_data_o(pdata[0]));

    mw_eeprom_wr #(.ORG_SEL(ORG_WORD), .START_ON_CLK(1'b1), .TWC(TWC), .TCSL(TCSL)) u1 (
        .clk(clk), .rst(rst), .cs_i(cs[1]), .sclk_i(sclk[1]), .sdi_i(di[1]), .org_i(org[1]),
        .sdo_o(sdo[1]), .sdo_en_o(sdo_en[1]), .peek_addr_i(paddr[1]), .peek_data_o(pdata[1]));

    // {org, address, data}
    localparam logic [25:0] VEC [4] = '{
        {1'b0, 9'h000, 16'h00A5},
        {1'b0, 9'h1FF, 16'h003C},
        {1'b1, 9'h012, 16'hBEEF},
        {1'b1, 9'h0FF, 16'h1234}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input int i, input logic [8:0] a, output logic [7:0] v);
        paddr[i] = a;
        #0.1;
        v = pdata[i];
    endtask

    task automatic sbit(input int i, input logic b);
        di[i] = b; sclk[i] = 1'b0; tick(2);
        sclk[i] = 1'b1; tick(2);
    endtask

    task automatic cs_low(input int i, input int n);
        sclk[i] = 1'b0; cs[i] = 1'b0; tick(n);
    endtask

    task automatic cs_high(input int i);
        cs[i] = 1'b1; tick(3);
    endtask

    task automatic send_write(input int i, input logic word, input logic [8:0] a,
                              input logic [15:0] d, input int lead, input int drop,
                              input logic [1:0] opc);
        int aw = word ? 8 : 9;
        int dw = word ? 16 : 8;
        cs_high(i);
        for (int k = 0; k < lead; k++) sbit(i, 1'b0);
        sbit(i, 1'b1);
        sbit(i, opc[1]);
        sbit(i, opc[0]);
        for (int k = aw - 1; k >= 0; k--) sbit(i, a[k]);
        for (int k = dw - 1; k >= drop; k--) sbit(i, d[k]);
        sclk[i] = 1'b0;
        tick(2);
    endtask

    task automatic clear_status(input int i);
        sbit(i, 1'b1);
        cs_low(i, 10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        logic [8:0] base;
        for (int k = 0; k < 512; k++) shadow[k] = 8'hFF;
        paddr[0] = '0; paddr[1] = '0;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R10: reset state
        check("R10 u0 drive off", 32'(sdo_en[0]), 0);
        check("R10 u1 drive off", 32'(sdo_en[1]), 0);
        peek(0, 9'h000, v); check("R10 byte 0 erased", 32'(v), 32'hFF);
        peek(0, 9'h1FF, v); check("R10 byte 1FF erased", 32'(v), 32'hFF);

        // Table walk on u0: both widths, full poll and clear sequence
        for (int n = 0; n < 4; n++) begin
            logic        w;
            logic [8:0]  a;
            logic [15:0] d;
            w = VEC[n][25]; a = VEC[n][24:16]; d = VEC[n][15:0];
            org[0] = w;
            base = w ? {a[7:0], 1'b0} : a;
            send_write(0, w, a, d, 0, 0, 2'b01);
            check("R8 undriven while shifting", 32'(sdo_en[0]), 0);
            tick(50);
            peek(0, base, v);
            check("R3 no start while CS held high", 32'(v), 32'(shadow[base]));
            cs_low(0, 10);
            check("R8 undriven while CS low", 32'(sdo_en[0]), 0);
            cs_high(0);
            check("R6 poll drives during programming", 32'(sdo_en[0]), 1);
            check("R6 busy reads 0", 32'(sdo[0]), 0);
            tick(TWC + 10);
            check("R6 ready reads 1", 32'(sdo[0]), 1);
            if (w) begin
                shadow[base] = d[7:0]; shadow[base + 1] = d[15:8];
                peek(0, base, v);       check("R2 word low byte", 32'(v), 32'(d[7:0]));
                peek(0, base + 9'd1, v2); check("R2 word high byte", 32'(v2), 32'(d[15:8]));
            end else begin
                shadow[base] = d[7:0];
                peek(0, base, v);       check("R2 byte stored", 32'(v), 32'(d[7:0]));
            end
            clear_status(0);
            cs_high(0);
            check("R7 status cleared", 32'(sdo_en[0]), 0);
            cs_low(0, 4);
        end

        // R6 short low time, R9 frame during programming, R5 timing
        org[0] = 1'b0;
        send_write(0, 1'b0, 9'h0AA, 16'h0077, 0, 0, 2'b01);
        cs_low(0, 2);
        cs_high(0);
        check("R6 short CS low gives no status", 32'(sdo_en[0]), 0);
        peek(0, 9'h0AA, v);
        check("R5 location unchanged mid-cycle", 32'(v), 32'hFF);
        cs_low(0, 10);
        cs_high(0);
        check("R6 long CS low gives status", 32'(sdo_en[0]), 1);
        check("R6 busy value", 32'(sdo[0]), 0);
        send_write(0, 1'b0, 9'h0AB, 16'h0099, 0, 0, 2'b01);
        cs_low(0, 10);
        tick(TWC + 20);
        peek(0, 9'h0AA, v); check("R5 location written after cycle", 32'(v), 32'h77);
        peek(0, 9'h0AB, v); check("R9 frame during programming ignored", 32'(v), 32'hFF);
        cs_high(0);
        check("R7 start bit of ignored frame cleared status", 32'(sdo_en[0]), 0);
        cs_low(0, 4);

        // R1 leading zeros skipped
        send_write(0, 1'b0, 9'h055, 16'h005A, 3, 0, 2'b01);
        cs_low(0, 10);
        tick(TWC + 10);
        peek(0, 9'h055, v); check("R1 leading zeros skipped", 32'(v), 32'h5A);

        // R9 wrong opcode
        send_write(0, 1'b0, 9'h077, 16'h0011, 0, 0, 2'b10);
        cs_low(0, 10);
        tick(TWC + 10);
        peek(0, 9'h077, v); check("R9 non-write opcode ignored", 32'(v), 32'hFF);

        // R3 frame cut short
        send_write(0, 1'b0, 9'h066, 16'h0042, 0, 1, 2'b01);
        cs_low(0, 10);
        tick(TWC + 10);
        peek(0, 9'h066, v); check("R3 short frame writes nothing", 32'(v), 32'hFF);
        cs_high(0);
        check("R3 short frame gives no status", 32'(sdo_en[0]), 0);
        cs_low(0, 4);

        // R4 clock-edge start on u1, word mode forced (org pin low)
        org[1] = 1'b0;
        send_write(1, 1'b1, 9'h040, 16'hCAFE, 0, 0, 2'b01);
        tick(3);
        peek(1, 9'h080, v); check("R5 u1 not yet written", 32'(v), 32'hFF);
        tick(TWC + 10);
        peek(1, 9'h080, v);  check("R4 written with CS high, low byte", 32'(v), 32'hFE);
        peek(1, 9'h081, v2); check("R2 forced word, high byte", 32'(v2), 32'hCA);
        cs_low(1, 10);
        cs_high(1);
        check("R6 u1 ready poll drives", 32'(sdo_en[1]), 1);
        check("R6 u1 ready value", 32'(sdo[1]), 1);
        cs_low(1, 4);
        send_write(1, 1'b1, 9'h041, 16'h0102, 0, 0, 2'b01);
        cs_low(1, 10);
        cs_high(1);
        check("R4 u1 busy right after frame", 32'(sdo[1]), 0);
        cs_low(1, 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule